// File: doc/BRIEF.md
# Vector CR-to-Integer Result Packer

This unit runs a vectorised reduction of condition-register (CR) fields into integer registers, one element per clock. For each of VL elements it reads a four-bit CR field, compares each bit with a mode pattern and gates it with a mask. It then folds the four qualified bits into one result bit, with an OR or an AND chosen by the any-select flag. The source can be a vector, so element i reads the field at base plus i. It can also be a scalar, so every element reads the same field.

The single-bit results are packed into integer registers. With a scalar destination, every result collects in one register: result i lands on bit i, counted from the least significant bit. With a vector destination, a two-bit element-width code taken from the CR side sets how many results share one register: one, two, four or eight. Element i goes to register base plus i/P at bit i mod P, and every bit above the packed ones is cleared. The unit keeps the bits for the current register and issues one write when that register is full or the last element is done.

A host starts an operation with a one-cycle start pulse that carries all the operands. It waits for the done pulse. The CR read port answers in the same cycle. The integer write port carries data together with a bit-level merge mask.

Top module: `crpk_top`

## Requirements
- R1: With a vector source, element i reads CR field cr_base+i, modulo the number of fields (64 by default), on consecutive cycles.
- R2: With a scalar source, every element reads field cr_base.
- R3: With field bit k, mask bit k and mode bit k (k = 0..3, bit 0 the LSB), the term n_k = mask[k] AND (mode[k] == field[k]). The result is the OR of the four terms when any_i=1 and their AND when any_i=0.
- R4: With a scalar destination, result i goes to bit i of register int_base. A single write has a merge mask covering exactly bits 0..VL-1, and the other bits of that register are unchanged.
- R5: With a vector destination, ew_i codes 0, 1, 2 and 3 give P = 1, 2, 4 and 8. Element i goes to register int_base + i/P (modulo 128) at bit i mod P.
- R6: Each vector-destination write has an all-ones merge mask, and every bit at position P or above is zero. A partly filled last register is still written, and its unused slots are zero.
- R7: VL=0 performs no write and gives done in the cycle after the start is accepted. A VL above 64 is treated as 64.
- R8: A write becomes visible one cycle after its last element is read. Done is a one-cycle pulse in the cycle after the final write, and no write happens during done.
- R9: A start that arrives while busy_o is high is ignored and does not alter the running operation.
- R10: After reset, busy_o, done_o, cr_rd_en_o and int_wr_en_o are low. While idle, neither port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| vl_i | input | 7 | Element count (0..64, larger values clamped) |
| cr_base_i | input | 6 | First CR field index |
| cr_vec_i | input | 1 | 1: source steps through fields; 0: one field |
| int_base_i | input | 7 | First integer register index |
| int_vec_i | input | 1 | 1: packed vector destination; 0: scalar destination |
| mask_i | input | 4 | Per-bit mask |
| mode_i | input | 4 | Per-bit compare pattern |
| any_i | input | 1 | 1: OR fold; 0: AND fold |
| ew_i | input | 2 | CR element-width code selecting the packing factor |
| busy_o | output | 1 | Operation in progress (accept through done) |
| done_o | output | 1 | One-cycle completion pulse |
| cr_rd_en_o | output | 1 | CR read strobe |
| cr_rd_idx_o | output | 6 | CR field index being read |
| cr_rd_data_i | input | 4 | CR field contents for cr_rd_idx_o, same cycle |
| int_wr_en_o | output | 1 | Integer write strobe |
| int_wr_idx_o | output | 7 | Integer register written |
| int_wr_data_o | output | 64 | Write data |
| int_wr_bits_o | output | 64 | Bit-level merge mask; only set bits are written |

## Verification
Each operation fills the CR file with fresh random values. Random mask, mode and fold choices therefore show whether each term tests equality against the mode and gates on the mask, with the AND and OR folds kept apart. Operations cover all four element-width codes with VL values that are not multiples of P, so the packing factor and the handling of a partial last register are tested separately. Scalar and vector sources and destinations are crossed. Directed cases add wrap of both index spaces, VL of 0, 64 and above 64, and a second start arriving mid-operation. Whole-register-file compares catch stray writes and clobbered neighbour bits, and cycle stamps check when each write and the done pulse appear.

// File: rtl/crpk_pkg.sv
package crpk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } crpk_state_e;

  // Fold four field bits: qualify each by mask and equality with mode.
  function automatic logic field_fold(input logic [3:0] fld,
                                      input logic [3:0] mask,
                                      input logic [3:0] mode,
                                      input logic       any);
    logic [3:0] hit;
    hit = mask & ~(mode ^ fld);
    return any ? (|hit) : (&hit);
  endfunction

  // Number of results sharing one destination register for a width code.
  function automatic int unsigned results_per_reg(input logic [1:0] ew);
    return 32'd1 << ew;
  endfunction

endpackage

// File: rtl/crpk_reduce.sv
module crpk_reduce (
  input  logic [3:0] fld_i,
  input  logic [3:0] mask_i,
  input  logic [3:0] mode_i,
  input  logic       any_i,
  output logic       bit_o
);
  logic [3:0] term;

  for (genvar k = 0; k < 4; k++) begin : g_term
    assign term[k] = mask_i[k] & (mode_i[k] == fld_i[k]);
  end

  assign bit_o = any_i ? (|term) : (&term);
endmodule

// File: rtl/crpk_place.sv
module crpk_place #(
  parameter int XLEN      = 64,
  parameter int VL_W      = 7,
  parameter int REG_IDX_W = 7,
  localparam int SLOT_W   = $clog2(XLEN),
  localparam int SH_W     = $clog2(SLOT_W + 1),
  localparam int WW       = (VL_W > SLOT_W + 1) ? VL_W : SLOT_W + 1
) (
  input  logic [VL_W-1:0]      elem_i,
  input  logic                 int_vec_i,
  input  logic [1:0]           ew_i,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [REG_IDX_W-1:0] reg_off_o,
  output logic                 full_o
);
  logic [SH_W-1:0] shamt;
  logic [WW-1:0]   span;
  logic [WW-1:0]   elem_w;
  logic [WW-1:0]   low;

  always_comb begin
    shamt     = int_vec_i ? SH_W'(ew_i) : SH_W'(SLOT_W);
    span      = (WW'(1) << shamt) - WW'(1);
    elem_w    = WW'(elem_i);
    low       = elem_w & span;
    slot_o    = SLOT_W'(low);
    reg_off_o = REG_IDX_W'(elem_w >> shamt);
    full_o    = (low == span);
  end
endmodule

// File: rtl/crpk_ctrl.sv
module crpk_ctrl
  import crpk_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            accept_o,
  output logic            run_o,
  output logic            last_o,
  output logic [VL_W-1:0] elem_o,
  output logic            busy_o,
  output logic            done_o
);
  crpk_state_e     state_q;
  logic [VL_W-1:0] elem_q;
  logic [VL_W-1:0] vl_q;
  logic [VL_W-1:0] vl_clamp;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign vl_clamp = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign run_o    = (state_q == ST_RUN);
  assign last_o   = run_o && (elem_q == vl_q - VL_W'(1));
  assign elem_o   = elem_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      vl_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_q    <= vl_clamp;
            elem_q  <= '0;
            state_q <= (vl_clamp == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_o) state_q <= ST_FLUSH;
          else        elem_q  <= elem_q + VL_W'(1);
        end
        ST_FLUSH: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crpk_top.sv
module crpk_top #(
  parameter int XLEN      = 64,
  parameter int MAX_VL    = 64,
  parameter int CR_IDX_W  = 6,
  parameter int REG_IDX_W = 7,
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int SLOT_W   = $clog2(XLEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [CR_IDX_W-1:0]  cr_base_i,
  input  logic                 cr_vec_i,
  input  logic [REG_IDX_W-1:0] int_base_i,
  input  logic                 int_vec_i,
  input  logic [3:0]           mask_i,
  input  logic [3:0]           mode_i,
  input  logic                 any_i,
  input  logic [1:0]           ew_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 cr_rd_en_o,
  output logic [CR_IDX_W-1:0]  cr_rd_idx_o,
  input  logic [3:0]           cr_rd_data_i,
  output logic                 int_wr_en_o,
  output logic [REG_IDX_W-1:0] int_wr_idx_o,
  output logic [XLEN-1:0]      int_wr_data_o,
  output logic [XLEN-1:0]      int_wr_bits_o
);
  // Operand latches
  logic [CR_IDX_W-1:0]  cr_base_q;
  logic                 cr_vec_q;
  logic [REG_IDX_W-1:0] int_base_q;
  logic                 int_vec_q;
  logic [3:0]           mask_q;
  logic [3:0]           mode_q;
  logic                 any_q;
  logic [1:0]           ew_q;

  // Control events, named for the checker
  logic            accept;
  logic            run;
  logic            last;
  logic [VL_W-1:0] elem;

  logic                 res_bit;
  logic [SLOT_W-1:0]    slot;
  logic [REG_IDX_W-1:0] reg_off;
  logic                 slot_full;
  logic                 emit;

  logic [XLEN-1:0] acc_q,  acc_nx;
  logic [XLEN-1:0] bits_q, bits_nx;

  logic                 wr_en_q;
  logic [REG_IDX_W-1:0] wr_idx_q;
  logic [XLEN-1:0]      wr_data_q;
  logic [XLEN-1:0]      wr_bits_q;

  crpk_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .accept_o (accept),
    .run_o    (run),
    .last_o   (last),
    .elem_o   (elem),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign cr_rd_en_o  = run;
  assign cr_rd_idx_o = cr_base_q + (cr_vec_q ? CR_IDX_W'(elem) : CR_IDX_W'(0));

  crpk_reduce u_reduce (
    .fld_i  (cr_rd_data_i),
    .mask_i (mask_q),
    .mode_i (mode_q),
    .any_i  (any_q),
    .bit_o  (res_bit)
  );

  crpk_place #(.XLEN(XLEN), .VL_W(VL_W), .REG_IDX_W(REG_IDX_W)) u_place (
    .elem_i    (elem),
    .int_vec_i (int_vec_q),
    .ew_i      (ew_q),
    .slot_o    (slot),
    .reg_off_o (reg_off),
    .full_o    (slot_full)
  );

  assign acc_nx  = acc_q  | (XLEN'(res_bit) << slot);
  assign bits_nx = bits_q | (XLEN'(1)       << slot);
  assign emit    = run && (last || slot_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_base_q  <= '0;
      cr_vec_q   <= 1'b0;
      int_base_q <= '0;
      int_vec_q  <= 1'b0;
      mask_q     <= '0;
      mode_q     <= '0;
      any_q      <= 1'b0;
      ew_q       <= '0;
    end else if (accept) begin
      cr_base_q  <= cr_base_i;
      cr_vec_q   <= cr_vec_i;
      int_base_q <= int_base_i;
      int_vec_q  <= int_vec_i;
      mask_q     <= mask_i;
      mode_q     <= mode_i;
      any_q      <= any_i;
      ew_q       <= ew_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bits_q <= '0;
    end else if (accept || emit) begin
      acc_q  <= '0;
      bits_q <= '0;
    end else if (run) begin
      acc_q  <= acc_nx;
      bits_q <= bits_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      wr_bits_q <= '0;
    end else begin
      wr_en_q <= emit;
      if (emit) begin
        wr_idx_q  <= int_base_q + reg_off;
        wr_data_q <= acc_nx;
        wr_bits_q <= int_vec_q ? {XLEN{1'b1}} : bits_nx;
      end
    end
  end

  assign int_wr_en_o   = wr_en_q;
  assign int_wr_idx_o  = wr_idx_q;
  assign int_wr_data_o = wr_data_q;
  assign int_wr_bits_o = wr_bits_q;
endmodule

// File: rtl/crpk_chk.sv
module crpk_chk
  import crpk_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int CR_IDX_W  = 6,
  parameter int REG_IDX_W = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 cr_rd_en_o,
  input logic [CR_IDX_W-1:0]  cr_rd_idx_o,
  input logic                 int_wr_en_o,
  input logic [REG_IDX_W-1:0] int_wr_idx_o,
  input logic [XLEN-1:0]      int_wr_data_o,
  input logic [XLEN-1:0]      int_wr_bits_o,
  input logic                 cr_vec_q,
  input logic                 int_vec_q,
  input logic [1:0]           ew_q
);
  logic                 seen_wr_q;
  logic [REG_IDX_W-1:0] prev_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr_q  <= 1'b0;
      prev_idx_q <= '0;
    end else if (!busy_o) begin
      seen_wr_q  <= 1'b0;
    end else if (int_wr_en_o) begin
      seen_wr_q  <= 1'b1;
      prev_idx_q <= int_wr_idx_o;
    end
  end

  // R1: vector source walks consecutive fields
  a_r1_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    cr_rd_en_o && $past(cr_rd_en_o) && cr_vec_q |->
      cr_rd_idx_o == $past(cr_rd_idx_o) + CR_IDX_W'(1));

  // R2: scalar source holds one field
  a_r2_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cr_rd_en_o && $past(cr_rd_en_o) && !cr_vec_q |-> $stable(cr_rd_idx_o));

  // R4: scalar destination is written once per operation
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr_en_o && !int_vec_q |-> !seen_wr_q);

  // R5: vector destination registers advance by one
  a_r5_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr_en_o && int_vec_q && seen_wr_q |->
      int_wr_idx_o == prev_idx_q + REG_IDX_W'(1));

  // R6: upper bits cleared, full-register merge
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr_en_o && int_vec_q |->
      ((int_wr_data_o >> results_per_reg(ew_q)) == '0) && (&int_wr_bits_o));

  // R8: done is a lone pulse, never alongside a write
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !int_wr_en_o);

  // R9: busy persists until done
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);

  // R10: quiet ports while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cr_rd_en_o && !int_wr_en_o);
endmodule

bind crpk_top crpk_chk #(.XLEN(XLEN), .CR_IDX_W(CR_IDX_W), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .cr_rd_en_o    (cr_rd_en_o),
  .cr_rd_idx_o   (cr_rd_idx_o),
  .int_wr_en_o   (int_wr_en_o),
  .int_wr_idx_o  (int_wr_idx_o),
  .int_wr_data_o (int_wr_data_o),
  .int_wr_bits_o (int_wr_bits_o),
  .cr_vec_q      (cr_vec_q),
  .int_vec_q     (int_vec_q),
  .ew_q          (ew_q)
);

// File: tb/crpk_top_tb_top.sv
`timescale 1ns/1ps
module crpk_top_tb_top;
  localparam int NCR  = 64;
  localparam int NREG = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [5:0]  cr_base = '0;
  logic        cr_vec = 1'b0;
  logic [6:0]  int_base = '0;
  logic        int_vec = 1'b0;
  logic [3:0]  mask = '0, mode = '0;
  logic        any = 1'b0;
  logic [1:0]  ew = '0;
  logic        busy, done, cr_rd_en, int_wr_en;
  logic [5:0]  cr_rd_idx;
  logic [3:0]  cr_rd_data;
  logic [6:0]  int_wr_idx;
  logic [63:0] int_wr_data, int_wr_bits;

  logic [3:0]  crf    [NCR];
  logic [63:0] rf     [NREG];
  logic [63:0] exp_rf [NREG];

  int cyc = 0, checks = 0, errors = 0;
  int wr_count = 0, done_count = 0, start_cyc = 0, last_wr_cyc = 0, done_cyc = 0;

  always #2.5 clk = ~clk;

  assign cr_rd_data = crf[cr_rd_idx];

  crpk_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vl_i(vl),
    .cr_base_i(cr_base), .cr_vec_i(cr_vec), .int_base_i(int_base), .int_vec_i(int_vec),
    .mask_i(mask), .mode_i(mode), .any_i(any), .ew_i(ew),
    .busy_o(busy), .done_o(done), .cr_rd_en_o(cr_rd_en), .cr_rd_idx_o(cr_rd_idx),
    .cr_rd_data_i(cr_rd_data), .int_wr_en_o(int_wr_en), .int_wr_idx_o(int_wr_idx),
    .int_wr_data_o(int_wr_data), .int_wr_bits_o(int_wr_bits)
  );

  // Port monitor, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (start && !busy && rst_n) start_cyc = cyc;
    if (int_wr_en) begin
      rf[int_wr_idx] = (rf[int_wr_idx] & ~int_wr_bits) | (int_wr_data & int_wr_bits);
      wr_count = wr_count + 1;
      last_wr_cyc = cyc;
    end
    if (done) begin
      done_count = done_count + 1;
      done_cyc = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // R3: agree = mask bits whose field bit equals the mode bit
  function automatic logic model_bit(input logic [3:0] f, input logic [3:0] m,
                                     input logic [3:0] md, input logic a);
    logic [3:0] agree;
    agree = m & ~(f ^ md);
    if (a) return agree != 4'h0;
    return agree == 4'hF;
  endfunction

  task automatic run_op(input int vl_in, input int cb, input bit cv, input int ib,
                        input bit iv, input logic [3:0] mk, input logic [3:0] md,
                        input bit a, input int e, input bit intrude);
    int eff, per, nexp, waited, bad, first_bad;
    string tag;
    eff = (vl_in > 64) ? 64 : vl_in;
    per = 1 << e;
    for (int k = 0; k < NREG; k++) exp_rf[k] = rf[k];
    for (int i = 0; i < eff; i++) begin
      int fidx, ridx, pos;
      logic r;
      fidx = cv ? (cb + i) % NCR : cb;
      r = model_bit(crf[fidx], mk, md, a);
      if (!iv) exp_rf[ib][i] = r;
      else begin
        ridx = (ib + i / per) % NREG;
        pos  = i % per;
        if (pos == 0) exp_rf[ridx] = 64'd0;
        exp_rf[ridx][pos] = r;
      end
    end
    nexp = (eff == 0) ? 0 : (iv ? (eff + per - 1) / per : 1);
    tag = {cv ? "R1" : "R2", iv ? " R5 R6" : " R4", " R3", intrude ? " R9" : ""};

    wr_count = 0; done_count = 0;
    @(posedge clk); #1;
    start = 1'b1; vl = 7'(vl_in); cr_base = 6'(cb); cr_vec = cv; int_base = 7'(ib);
    int_vec = iv; mask = mk; mode = md; any = a; ew = 2'(e);
    @(posedge clk); #1;
    start = 1'b0;
    if (intrude) begin
      @(posedge clk); #1;
      start = 1'b1; vl = 7'd3; cr_base = 6'(cb + 5); cr_vec = ~cv; int_base = 7'(ib + 9);
      int_vec = ~iv; mask = ~mk; mode = ~md; any = ~a; ew = 2'(e + 1);
      @(posedge clk); #1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    waited = 0;
    while (done_count == 0 && waited < 400) begin
      @(posedge clk); waited++;
    end
    @(negedge clk); @(negedge clk);
    chk(done_count == 1, "R8", "done pulse count", done_count, 1);
    bad = 0; first_bad = -1;
    for (int k = 0; k < NREG; k++)
      if (rf[k] !== exp_rf[k]) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    if (first_bad < 0) chk(1'b1, tag, "register file", 0, 0);
    else chk(1'b0, tag, $sformatf("register %0d", first_bad), rf[first_bad], exp_rf[first_bad]);
    chk(wr_count == nexp, iv ? "R6" : "R4", "write count", wr_count, nexp);
    if (eff == 0)
      chk(done_cyc - start_cyc == 1, "R7", "done delay for VL 0", done_cyc - start_cyc, 1);
    else begin
      chk(last_wr_cyc - start_cyc == eff + 1, "R8", "final write cycle",
          last_wr_cyc - start_cyc, eff + 1);
      chk(done_cyc - last_wr_cyc == 1, "R8", "done after final write",
          done_cyc - last_wr_cyc, 1);
    end
  endtask

  task automatic fill_crf();
    for (int k = 0; k < NCR; k++) crf[k] = 4'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int k = 0; k < NREG; k++) rf[k] = {$urandom, $urandom};
    fill_crf();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    chk(!cr_rd_en && !int_wr_en, "R10", "ports idle after reset", {cr_rd_en, int_wr_en}, 0);

    // Directed corners
    run_op(0, 3, 1, 10, 1, 4'hF, 4'h0, 1, 2, 0);            // R7 empty
    run_op(64, 0, 1, 20, 0, 4'hF, 4'h5, 1, 0, 0);           // R4 full scalar
    fill_crf();
    run_op(100, 7, 1, 30, 0, 4'h3, 4'h0, 0, 0, 0);          // R7 clamp
    run_op(5, 60, 1, 126, 1, 4'hF, 4'hA, 0, 0, 0);          // R1 wrap, R5 ew 0 reg wrap
    run_op(7, 12, 1, 40, 1, 4'h6, 4'h2, 1, 1, 0);           // R6 ew 1 partial
    run_op(10, 20, 0, 50, 1, 4'h9, 4'h1, 1, 2, 0);          // R2, ew 2 partial
    run_op(19, 33, 1, 60, 1, 4'hC, 4'h4, 1, 3, 0);          // ew 3 partial
    run_op(9, 8, 1, 70, 0, 4'h0, 4'h0, 1, 0, 0);            // R3 empty mask OR
    run_op(9, 8, 1, 71, 0, 4'h0, 4'h0, 0, 0, 0);            // R3 empty mask AND
    run_op(12, 40, 1, 80, 1, 4'hB, 4'h7, 0, 2, 1);          // R9 intruder

    // Random mix
    for (int n = 0; n < 40; n++) begin
      fill_crf();
      run_op(int'($urandom % 70), int'($urandom % NCR), 1'($urandom), int'($urandom % NREG),
             1'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), int'($urandom % 4),
             ($urandom % 5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule